// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This block keeps wall-clock time as a free-running binary count of seconds and exposes it through a small byte-wide register port. A one-cycle `tick` strobe, produced elsewhere once per second, advances the count while the run bit is set. A new time is loaded in pieces. The upper bytes go into holding registers first. The write of the lowest byte then loads the whole value into the counter in a single cycle. Software should first write the lowest byte as zero, then the upper bytes, then the lowest byte with its final value.

The current time is read byte by byte straight from the live counter. No copy is frozen, so a carry can land between two byte reads. Software detects this by reading the lowest byte again: if it came back smaller, the count rolled over and the read must be repeated.

An alarm compare value, also written byte by byte, is checked against the counter after every tick-driven step. On a match with the alarm enabled, a sticky status bit sets and the interrupt line rises. Both stay until software writes the clear bit.

Top module: `secs_rtc`

## Requirements
- R1: After a synchronous reset, the following are all zero: the counter, the holding bytes, the alarm value, the run and alarm-enable bits, the alarm status, `rdata` and `alarm_irq`.
- R2: While bit 7 of the control byte (offset 0) is 1, every `tick` adds one to the counter at that clock edge. While the bit is 0, the counter holds its value.
- R3: A write to offsets 3, 4 or 5 loads only holding byte 1, 2 or 3 and leaves the counter unchanged. A write to offset 2 loads the counter with {byte3, byte2, byte1, wdata} at that edge. A write to offset 2 wins over a `tick` in the same cycle.
- R4: Offsets 6 to 9 return counter bytes 0 to 3, lowest byte first, taken live with no snapshot. A carry between two byte reads is therefore visible.
- R5: Offsets 10 to 13 hold the alarm value, lowest byte first, and read back what was written.
- R6: The alarm status sets at the edge after a tick-driven step, when the counter equals the alarm value and bit 1 of the control byte is 1. `alarm_irq` equals status AND enable, and updates at the same edge as the status.
- R7: Loading the counter with a value equal to the alarm value never sets the alarm status.
- R8: The alarm status reads as bit 0 of offset 1. It stays set through later ticks and while the enable is 0, until a write to offset 1 with bit 0 set clears it. A set and a clear in the same cycle leave the status set.
- R9: `rdata` is registered. It is loaded only when `rd_en` is high, and shows the state from before that edge. Offset 0 reads back only bits 7 and 1. Offsets 2 to 5 and 14 to 15 read as zero.
- R10: The counter wraps from all ones to zero on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle seconds strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
A write or a `tick` shows up in the counter one edge after the cycle that carries it. Read data shows up one edge after the `rd_en` cycle. The alarm status and `alarm_irq` follow a matching tick by two edges: one for the step and one for the compare. The bench drives every input just after a falling edge and samples just after the next one. Every directed check therefore sits at a known edge count from its stimulus. A behavioural model updated on each rising edge is compared against `alarm_irq` on every cycle, and against `rdata` after every read.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
  // register offsets; the read and alarm windows follow the write window
  localparam int CTRL_OFF = 0;
  localparam int ACTL_OFF = 1;
  localparam int WR_BASE  = 2;
  // bit positions decoded by software
  localparam int RUN_BIT  = 7;
  localparam int AEN_BIT  = 1;
  localparam int CLR_BIT  = 0;
  localparam int STAT_BIT = 0;
endpackage

// File: rtl/secs_rtc_regs.sv
module secs_rtc_regs
  import secs_rtc_pkg::*;
#(
  parameter int DW = 8,
  parameter int NB = 4,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic             run,
  output logic             aen,
  output logic             aen_nxt,
  output logic             clr,
  output logic             commit,
  output logic [NB*DW-1:0] commit_val,
  output logic [NB*DW-1:0] alarm_val
);
  localparam int AL_BASE = WR_BASE + 2 * NB;
  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_OFF);
  localparam logic [AW-1:0] A_ACTL = AW'(ACTL_OFF);
  localparam logic [AW-1:0] A_WR0  = AW'(WR_BASE);

  logic                   run_q, aen_q;
  logic [(NB-1)*DW-1:0]   stg_q;
  logic [NB*DW-1:0]       alm_q;
  logic                   ctrl_wr;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign aen_nxt = ctrl_wr ? wdata[AEN_BIT] : aen_q;
  assign clr     = wr_en && (addr == A_ACTL) && wdata[CLR_BIT];
  assign commit  = wr_en && (addr == A_WR0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      aen_q <= 1'b0;
    end else begin
      if (ctrl_wr) run_q <= wdata[RUN_BIT];
      aen_q <= aen_nxt;
    end
  end

  // holding bytes 1..NB-1; byte 0 is never stored, it commits
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      for (int i = 1; i < NB; i++) begin
        if (wr_en && (addr == AW'(WR_BASE + i)))
          stg_q[(i-1)*DW +: DW] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_q <= '0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (wr_en && (addr == AW'(AL_BASE + i)))
          alm_q[i*DW +: DW] <= wdata;
      end
    end
  end

  assign commit_val = {stg_q, wdata};
  assign alarm_val  = alm_q;
  assign run        = run_q;
  assign aen        = aen_q;
endmodule

// File: rtl/secs_rtc_count.sv
module secs_rtc_count #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          commit,
  input  logic [CW-1:0] commit_val,
  output logic [CW-1:0] cnt,
  output logic          armed
);
  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (commit)
        cnt_q <= commit_val;
      else if (run && tick)
        cnt_q <= cnt_q + CW'(1);
      // only a tick step may arm the compare
      armed_q <= run && tick && !commit;
    end
  end

  assign cnt   = cnt_q;
  assign armed = armed_q;
endmodule

// File: rtl/secs_rtc_alarm.sv
module secs_rtc_alarm #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          armed,
  input  logic          aen,
  input  logic          aen_nxt,
  input  logic          clr,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] alarm_val,
  output logic          status,
  output logic          irq
);
  logic hit, status_n, status_q, irq_q;

  assign hit      = armed && aen && (cnt == alarm_val);
  assign status_n = hit || (status_q && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      irq_q    <= status_n && aen_nxt;
    end
  end

  assign status = status_q;
  assign irq    = irq_q;
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import secs_rtc_pkg::*;
#(
  parameter int DW = 8,
  parameter int NB = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          alarm_irq
);
  localparam int CW      = NB * DW;
  localparam int RD_BASE = WR_BASE + NB;
  localparam int AL_BASE = RD_BASE + NB;
  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_OFF);
  localparam logic [AW-1:0] A_ACTL = AW'(ACTL_OFF);

  logic          run, aen, aen_nxt, clr, commit, armed, status;
  logic [CW-1:0] commit_val, alarm_val, cnt;
  logic [DW-1:0] rsel, rdata_q;

  secs_rtc_regs #(.DW(DW), .NB(NB), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .run(run), .aen(aen), .aen_nxt(aen_nxt), .clr(clr), .commit(commit),
    .commit_val(commit_val), .alarm_val(alarm_val)
  );

  secs_rtc_count #(.CW(CW)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .commit(commit),
    .commit_val(commit_val), .cnt(cnt), .armed(armed)
  );

  secs_rtc_alarm #(.CW(CW)) u_alarm (
    .clk(clk), .rst(rst), .armed(armed), .aen(aen), .aen_nxt(aen_nxt),
    .clr(clr), .cnt(cnt), .alarm_val(alarm_val), .status(status),
    .irq(alarm_irq)
  );

  always_comb begin
    rsel = '0;
    if (addr == A_CTRL) begin
      rsel[RUN_BIT] = run;
      rsel[AEN_BIT] = aen;
    end
    if (addr == A_ACTL) rsel[STAT_BIT] = status;
    for (int i = 0; i < NB; i++) begin
      if (addr == AW'(RD_BASE + i)) rsel = cnt[i*DW +: DW];
      if (addr == AW'(AL_BASE + i)) rsel = alarm_val[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rsel;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk
  import secs_rtc_pkg::*;
#(
  parameter int DW = 8,
  parameter int NB = 4,
  parameter int AW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic             alarm_irq,
  input logic [NB*DW-1:0] cnt,
  input logic             run,
  input logic             aen,
  input logic             status,
  input logic             armed
);
  localparam int CW = NB * DW;
  logic commit_w, clr_w;
  assign commit_w = wr_en && (addr == AW'(WR_BASE));
  assign clr_w    = wr_en && (addr == AW'(ACTL_OFF)) && wdata[CLR_BIT];

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !commit_w) |=> $stable(cnt)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !commit_w) |=> (cnt == $past(cnt) + CW'(1))); // R2
  AST_COMMIT_LOW: assert property (@(posedge clk) disable iff (rst)
    commit_w |=> (cnt[DW-1:0] == $past(wdata))); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    alarm_irq |-> (aen && status)); // R6
  AST_NO_COMMIT_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(status) |-> $past(run && tick && !commit_w, 2)); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status && !clr_w) |=> status); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (clr_w && !armed) |=> !status); // R8
endmodule

bind secs_rtc secs_rtc_chk #(.DW(DW), .NB(NB), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .alarm_irq(alarm_irq), .cnt(cnt), .run(run), .aen(aen),
  .status(status), .armed(armed)
);

// File: tb/secs_rtc_test.sv
`timescale 1ns/1ps
module secs_rtc_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       alarm_irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  secs_rtc uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_irq(alarm_irq)
  );

  // behavioural reference model
  logic [31:0] m_cnt, m_alm;
  logic [7:0]  m_stg [1:3];
  logic        m_run, m_aen, m_stat, m_armed, m_irq, m_rv;
  logic [7:0]  m_rd;

  always @(posedge clk) begin
    logic commit, setc, clrc, n_stat, n_aen;
    logic [7:0] rv;
    if (rst) begin
      m_cnt = 0; m_alm = 0; m_run = 0; m_aen = 0; m_stat = 0;
      m_armed = 0; m_irq = 0; m_rd = 0; m_rv = 0;
      for (int i = 1; i < 4; i++) m_stg[i] = 0;
    end else begin
      commit = wr_en && addr == 2;
      setc   = m_armed && m_aen && (m_cnt == m_alm);
      clrc   = wr_en && addr == 1 && wdata[0];
      n_stat = setc ? 1'b1 : (clrc ? 1'b0 : m_stat);
      n_aen  = (wr_en && addr == 0) ? wdata[1] : m_aen;
      rv = 0;
      if (addr == 0) rv = {m_run, 5'd0, m_aen, 1'b0};
      else if (addr == 1) rv = {7'd0, m_stat};
      else if (addr >= 6 && addr <= 9) rv = m_cnt[(addr-6)*8 +: 8];
      else if (addr >= 10 && addr <= 13) rv = m_alm[(addr-10)*8 +: 8];
      m_rv = rd_en;
      if (rd_en) m_rd = rv;
      m_armed = m_run && tick && !commit;
      if (commit) m_cnt = {m_stg[3], m_stg[2], m_stg[1], wdata};
      else if (m_run && tick) m_cnt = m_cnt + 1;
      if (wr_en) begin
        if (addr == 0) m_run = wdata[7];
        if (addr >= 3 && addr <= 5) m_stg[addr-2] = wdata;
        if (addr >= 10 && addr <= 13) m_alm[(addr-10)*8 +: 8] = wdata;
      end
      m_aen = n_aen; m_stat = n_stat; m_irq = n_stat && n_aen;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle model comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({31'd0, alarm_irq}, {31'd0, m_irq}, "R6 irq vs model");
      if (m_rv) chk({24'd0, rdata}, {24'd0, m_rd}, "R9 rdata vs model");
    end
  end

  task automatic step(input logic we, input logic re, input logic tk,
                      input logic [3:0] a, input logic [7:0] d);
    wr_en = we; rd_en = re; tick = tk; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0; tick = 0;
  endtask
  task automatic wr(input logic [3:0] a, input logic [7:0] d); step(1, 0, 0, a, d); endtask
  task automatic tk(); step(0, 0, 1, 0, 0); endtask
  task automatic idle(); step(0, 0, 0, 0, 0); endtask
  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    step(0, 1, 0, a, 0);
    chk({24'd0, rdata}, {24'd0, e}, tag);
  endtask
  task automatic set_time(input logic [31:0] v);
    wr(2, 0); wr(3, v[15:8]); wr(4, v[23:16]); wr(5, v[31:24]); wr(2, v[7:0]);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk({31'd0, alarm_irq}, 0, "R1 irq after reset");
        rd(0, 8'h00, "R1 ctrl"); rd(1, 8'h00, "R1 status");
        rd(6, 8'h00, "R1 time byte0"); rd(13, 8'h00, "R1 alarm byte3");
        // R9 ctrl readback masks bits
        wr(0, 8'hFF); rd(0, 8'h82, "R9 ctrl readback"); wr(0, 8'h00);
        // R2 run / hold
        wr(0, 8'h80); tk(); tk(); tk(); rd(6, 8'h03, "R2 counts ticks");
        wr(0, 8'h00); tk(); tk(); rd(6, 8'h03, "R2 holds when stopped");
        // R3 staging then commit
        wr(3, 8'h11); wr(4, 8'h22); wr(5, 8'h33);
        rd(7, 8'h00, "R3 staging leaves byte1"); rd(6, 8'h03, "R3 staging leaves byte0");
        wr(2, 8'h44);
        rd(6, 8'h44, "R3 commit byte0"); rd(8, 8'h22, "R3 commit byte2"); rd(9, 8'h33, "R3 commit byte3");
        // R4 live read with carry
        set_time(32'h0000_00FF); wr(0, 8'h80);
        rd(6, 8'hFF, "R4 low byte before carry"); tk();
        rd(6, 8'h00, "R4 low byte after carry"); rd(7, 8'h01, "R4 carry into byte1");
        step(0, 1, 1, 6, 0); chk({24'd0, rdata}, 0, "R4 read shows pre-tick value");
        rd(6, 8'h01, "R4 live after tick");
        // R5 alarm bytes
        wr(10, 8'h05); wr(11, 8'h01); wr(12, 8'h00); wr(13, 8'h00);
        rd(10, 8'h05, "R5 alarm byte0"); rd(11, 8'h01, "R5 alarm byte1");
        // R6 match after tick
        wr(0, 8'h82); tk(); tk(); tk(); tk();
        chk({31'd0, alarm_irq}, 0, "R6 irq not yet on step edge");
        idle(); chk({31'd0, alarm_irq}, 1, "R6 irq on compare edge");
        rd(1, 8'h01, "R8 status visible");
        // R8 sticky with enable off, clear
        wr(0, 8'h80); chk({31'd0, alarm_irq}, 0, "R6 irq gated by enable");
        tk(); rd(1, 8'h01, "R8 status survives disable and tick");
        wr(0, 8'h82); chk({31'd0, alarm_irq}, 1, "R8 irq returns on enable");
        wr(1, 8'h01); chk({31'd0, alarm_irq}, 0, "R8 clear drops irq");
        rd(1, 8'h00, "R8 status cleared");
        // R7 commit onto alarm value
        set_time(32'h0000_0105); idle(); idle();
        chk({31'd0, alarm_irq}, 0, "R7 commit does not alarm");
        rd(1, 8'h00, "R7 status stays clear");
        // R8 set wins over same-cycle clear
        set_time(32'h0000_0104); tk(); wr(1, 8'h01);
        chk({31'd0, alarm_irq}, 1, "R8 set wins over clear");
        wr(1, 8'h01); chk({31'd0, alarm_irq}, 0, "R8 cleared again");
        // R3 commit beats tick
        step(1, 0, 1, 2, 8'h50); rd(6, 8'h50, "R3 commit wins over tick");
        rd(7, 8'h01, "R3 commit upper byte");
        // R10 wrap
        wr(10, 0); wr(11, 0); set_time(32'hFFFF_FFFF); tk();
        rd(6, 8'h00, "R10 wrap byte0"); rd(9, 8'h00, "R10 wrap byte3");
        chk({31'd0, alarm_irq}, 1, "R6 alarm at wrapped zero");
        // R9 unmapped and write-only offsets
        rd(14, 8'h00, "R9 unmapped reads zero"); rd(3, 8'h00, "R9 staging reads zero");
      end
    join_any
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule